// File: doc/BRIEF.md
# Memory-Mapped GPIO Bank with Line Interrupts

This block is a general-purpose I/O bank that sits on an APB slave bus. It serves up to four ports of up to 32 lines each. Software sets each line's output value and drive direction, and reads back the synchronized pin levels. The first port (port 0) also carries per-line interrupt logic and per-line debounce. The other ports are plain I/O. One interrupt output is raised whenever any enabled, unmasked line on port 0 is active. Pad drivers, the debounce sample clock and both-edge emulation sit outside the block. The block receives only a one-cycle sample tick for the debounce counters.

Each pad input passes through a two-flop synchronizer. On port 0, a line can instead be taken through a debouncer. The debouncer accepts a new level only after the level has held for a set number of sample ticks. The interrupt logic sees the same line value that software reads. An input strap picks one of two offset maps for the interrupt registers. The data, direction and pin registers keep the same offsets in both maps.

Top module: `gpio_apb_bank`

## Requirements
- R1: The data register of port p is at offset 0x0C·p and its direction register is at 0x0C·p+4. Both read back what was written. A line drives its pad (`pad_oe`=1) exactly when its direction bit is 1, and `pad_out` carries the data bit. Port p occupies bits [32p+31:32p] of both pad buses.
- R2: The read-only pin register of port p is at 0x50+4·p. For ports 1 to 3 it returns `pad_in` delayed by two clock edges. For port 0 it returns the line value after the optional debouncer.
- R3: A read of an offset that no register decodes returns zero. A write to such an offset changes no register and no output. With the default map, 0x08 and 0x44 are undecoded; with the alternate map, 0x4C is undecoded.
- R4: With `alt_layout`=0, port 0's interrupt registers are: enable 0x30, mask 0x34, type 0x38, polarity 0x3C, status 0x40 (read-only), debounce enable 0x48 and end-of-interrupt 0x4C (write-only, reads zero). With `alt_layout`=1, mask moves to 0x44, type to 0x34, polarity to 0x38, status to 0x3C and end-of-interrupt to 0x40.
- R5: A status bit reads 1 only when the line is armed (enable bit 1) and not suppressed (mask bit 1 suppresses). `irq` is the OR of all status bits.
- R6: For a line whose type bit is 1 (level), the status bit follows the line value. It is active when the value equals the polarity bit (1 = active high, 0 = active low).
- R7: For a line whose type bit is 0 (edge), an armed rising transition (polarity 1) or falling transition (polarity 0) is latched. Writing a 1 to that bit of end-of-interrupt clears the latch, and writing all ones clears every latch. End-of-interrupt writes do not affect level lines. Disarming a line or switching it to level discards its latch.
- R8: For a port 0 line whose debounce bit is 1, the value seen by software and the interrupt logic changes only after the synchronized input has differed from it on `DB_TICKS` sample ticks in a row. Any return to the old level restarts the count, and cycles without a tick do not count.
- R9: Pin changes on ports 1 to 3 never set a status bit or `irq`.
- R10: After reset, every register reads zero, and `pad_out`, `pad_oe` and `irq` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and logic clock |
| presetn | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 8 | APB byte offset |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, zero outside read transfers |
| pready | output | 1 | Always 1: no wait states |
| alt_layout | input | 1 | Strap that selects the alternate interrupt register map |
| db_tick | input | 1 | One-cycle debounce sample tick |
| pad_in | input | NP·W | Pad input levels, port p at bits [W·p+W-1:W·p] |
| pad_out | output | NP·W | Output values taken from the data registers |
| pad_oe | output | NP·W | Output enables taken from the direction registers |
| irq | output | 1 | Combined port 0 interrupt |

## Verification
The hardest states to reach are those where the debounce counters and the edge latches interact with bus traffic. Examples are a glitch that ends one tick short of acceptance, a stretch without sample ticks in the middle of a change, and an end-of-interrupt write that lands while new edges are arriving. The directed part of the stimulus builds the short pulse, the held pulse and the stalled tick explicitly. A pseudo-random phase then toggles port 0 pins, gates the tick and interleaves status reads with clear writes, all under both-polarity edge and level lines. A behavioural model checks every cycle of this phase.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int APB_AW    = 8;
  localparam int APB_DW    = 32;
  localparam int MAX_PORTS = 4;

  localparam logic [7:0] OFS_DATA0   = 8'h00;
  localparam logic [7:0] OFS_DIR0    = 8'h04;
  localparam logic [7:0] PORT_STRIDE = 8'h0C;
  localparam logic [7:0] OFS_PIN0    = 8'h50;
  localparam logic [7:0] PIN_STRIDE  = 8'h04;
  localparam logic [7:0] OFS_IEN     = 8'h30;
  localparam logic [7:0] OFS_DEB     = 8'h48;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_DATA, SEL_DIR, SEL_PIN, SEL_IEN, SEL_IMASK,
    SEL_ITYPE, SEL_IPOL, SEL_ISTAT, SEL_DEB, SEL_EOI
  } reg_sel_e;

  typedef struct packed {
    reg_sel_e   sel;
    logic [1:0] port;
  } reg_hit_t;

  // Offset decode; the strap moves five of the interrupt registers.
  function automatic reg_hit_t decode_addr(input logic [7:0] a, input logic alt,
                                           input int nports);
    reg_hit_t h;
    h.sel  = SEL_NONE;
    h.port = '0;
    for (int p = 0; p < MAX_PORTS; p++) begin
      if (p < nports) begin
        if (a == OFS_DATA0 + 8'(p) * PORT_STRIDE) begin
          h.sel = SEL_DATA; h.port = 2'(p);
        end
        if (a == OFS_DIR0 + 8'(p) * PORT_STRIDE) begin
          h.sel = SEL_DIR; h.port = 2'(p);
        end
        if (a == OFS_PIN0 + 8'(p) * PIN_STRIDE) begin
          h.sel = SEL_PIN; h.port = 2'(p);
        end
      end
    end
    if (a == OFS_IEN) h.sel = SEL_IEN;
    if (a == OFS_DEB) h.sel = SEL_DEB;
    if (alt) begin
      case (a)
        8'h44:   h.sel = SEL_IMASK;
        8'h34:   h.sel = SEL_ITYPE;
        8'h38:   h.sel = SEL_IPOL;
        8'h3C:   h.sel = SEL_ISTAT;
        8'h40:   h.sel = SEL_EOI;
        default: ;
      endcase
    end else begin
      case (a)
        8'h34:   h.sel = SEL_IMASK;
        8'h38:   h.sel = SEL_ITYPE;
        8'h3C:   h.sel = SEL_IPOL;
        8'h40:   h.sel = SEL_ISTAT;
        8'h4C:   h.sel = SEL_EOI;
        default: ;
      endcase
    end
    return h;
  endfunction
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce #(
  parameter int W     = 32,
  parameter int TICKS = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  function automatic logic settle_done(input logic [CW-1:0] c);
    return c == LAST;
  endfunction

  for (genvar i = 0; i < W; i++) begin : g_line
    logic [CW-1:0] cnt;
    logic          acc;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt <= '0;
        acc <= 1'b0;
      end else if (din[i] == acc) begin
        cnt <= '0;
      end else if (tick) begin
        if (settle_done(cnt)) begin
          acc <= din[i];
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end

    assign dout[i] = acc;
  end
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] en,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] typ,
  input  logic [W-1:0] pol,
  input  logic         eoi_stb,
  input  logic [W-1:0] eoi_val,
  output logic [W-1:0] status,
  output logic [W-1:0] edge_latch,
  output logic [W-1:0] edge_ev,
  output logic         irq
);
  function automatic logic [W-1:0] edge_hit(input logic [W-1:0] cur,
                                            input logic [W-1:0] prv,
                                            input logic [W-1:0] p);
    return (p & cur & ~prv) | (~p & ~cur & prv);
  endfunction

  function automatic logic [W-1:0] level_hit(input logic [W-1:0] cur,
                                             input logic [W-1:0] p);
    return ~(cur ^ p);
  endfunction

  logic [W-1:0] prev_q, latch_q, clr, raw;

  assign clr     = eoi_stb ? eoi_val : '0;
  assign edge_ev = en & ~typ & edge_hit(lvl, prev_q, pol);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      latch_q <= '0;
    end else begin
      prev_q  <= lvl;
      latch_q <= en & ~typ & ((latch_q & ~clr) | edge_ev);
    end
  end

  assign raw        = (typ & level_hit(lvl, pol)) | (~typ & latch_q);
  assign status     = raw & en & ~mask;
  assign edge_latch = latch_q;
  assign irq        = |status;
endmodule

// File: rtl/gpio_apb_bank.sv
module gpio_apb_bank #(
  parameter int NP       = 4,
  parameter int W        = 32,
  parameter int DB_TICKS = 4
) (
  input  logic                             pclk,
  input  logic                             presetn,
  input  logic                             psel,
  input  logic                             penable,
  input  logic                             pwrite,
  input  logic [gpio_bank_pkg::APB_AW-1:0] paddr,
  input  logic [gpio_bank_pkg::APB_DW-1:0] pwdata,
  output logic [gpio_bank_pkg::APB_DW-1:0] prdata,
  output logic                             pready,
  input  logic                             alt_layout,
  input  logic                             db_tick,
  input  logic [NP*W-1:0]                  pad_in,
  output logic [NP*W-1:0]                  pad_out,
  output logic [NP*W-1:0]                  pad_oe,
  output logic                             irq
);
  import gpio_bank_pkg::*;

  localparam int PW = NP * W;

  logic [NP-1:0][W-1:0] reg_data, reg_dir, pad_sync;
  logic [W-1:0] int_en, int_mask, int_type, int_pol, deb_en;
  logic [W-1:0] db_out, line_a, status, edge_latch, edge_ev, eoi_val, rd_word;
  logic         wr_stb, eoi_stb;
  reg_hit_t     hit;

  gpio_sync2 #(.W(PW)) u_sync (
    .clk(pclk), .rst_n(presetn), .d(pad_in), .q(pad_sync)
  );

  gpio_debounce #(.W(W), .TICKS(DB_TICKS)) u_deb (
    .clk(pclk), .rst_n(presetn), .tick(db_tick),
    .din(pad_sync[0]), .dout(db_out)
  );

  assign line_a = (deb_en & db_out) | (~deb_en & pad_sync[0]);

  assign hit     = decode_addr(paddr, alt_layout, NP);
  assign wr_stb  = psel & penable & pwrite;
  assign eoi_stb = wr_stb && (hit.sel == SEL_EOI);
  assign eoi_val = pwdata[W-1:0];

  gpio_irq_unit #(.W(W)) u_irq (
    .clk(pclk), .rst_n(presetn), .lvl(line_a),
    .en(int_en), .mask(int_mask), .typ(int_type), .pol(int_pol),
    .eoi_stb(eoi_stb), .eoi_val(eoi_val),
    .status(status), .edge_latch(edge_latch), .edge_ev(edge_ev), .irq(irq)
  );

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      reg_data <= '0;
      reg_dir  <= '0;
      int_en   <= '0;
      int_mask <= '0;
      int_type <= '0;
      int_pol  <= '0;
      deb_en   <= '0;
    end else if (wr_stb) begin
      case (hit.sel)
        SEL_DATA:  reg_data[hit.port] <= pwdata[W-1:0];
        SEL_DIR:   reg_dir[hit.port]  <= pwdata[W-1:0];
        SEL_IEN:   int_en   <= pwdata[W-1:0];
        SEL_IMASK: int_mask <= pwdata[W-1:0];
        SEL_ITYPE: int_type <= pwdata[W-1:0];
        SEL_IPOL:  int_pol  <= pwdata[W-1:0];
        SEL_DEB:   deb_en   <= pwdata[W-1:0];
        default:   ;
      endcase
    end
  end

  always_comb begin
    rd_word = '0;
    case (hit.sel)
      SEL_DATA:  rd_word = reg_data[hit.port];
      SEL_DIR:   rd_word = reg_dir[hit.port];
      SEL_PIN:   rd_word = (hit.port == 2'd0) ? line_a : pad_sync[hit.port];
      SEL_IEN:   rd_word = int_en;
      SEL_IMASK: rd_word = int_mask;
      SEL_ITYPE: rd_word = int_type;
      SEL_IPOL:  rd_word = int_pol;
      SEL_ISTAT: rd_word = status;
      SEL_DEB:   rd_word = deb_en;
      default:   rd_word = '0;
    endcase
  end

  assign prdata  = (psel && !pwrite) ? APB_DW'(rd_word) : '0;
  assign pready  = 1'b1;
  assign pad_out = reg_data;
  assign pad_oe  = reg_dir;
endmodule

// File: rtl/gpio_apb_bank_chk.sv
module gpio_apb_bank_chk #(
  parameter int NP = 4,
  parameter int W  = 32
) (
  input logic            pclk,
  input logic            presetn,
  input logic            psel,
  input logic            penable,
  input logic            pwrite,
  input logic [7:0]      paddr,
  input logic [31:0]     pwdata,
  input logic            db_tick,
  input logic [NP*W-1:0] pad_in,
  input logic [NP*W-1:0] pad_sync,
  input logic [NP*W-1:0] pad_oe,
  input logic            irq,
  input logic [W-1:0]    int_en,
  input logic [W-1:0]    int_mask,
  input logic [W-1:0]    edge_latch,
  input logic [W-1:0]    edge_ev,
  input logic            eoi_stb,
  input logic [W-1:0]    eoi_val,
  input logic [W-1:0]    db_out
);
  logic [1:0] since_rst;

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn)               since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R1: a write to port 0 direction shows on the enables next cycle
  p_dir_write_r1: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && penable && pwrite && paddr == 8'h04) |=> pad_oe[W-1:0] == $past(pwdata[W-1:0]));

  // R2: synchronized pins trail the pads by two edges
  p_sync_lat_r2: assert property (@(posedge pclk) disable iff (!presetn)
    (since_rst == 2'd3) |-> pad_sync == $past(pad_in, 2));

  // R5: an interrupt needs an armed, unmasked line
  p_irq_cause_r5: assert property (@(posedge pclk) disable iff (!presetn)
    irq |-> |(int_en & ~int_mask));

  // R7: cleared latches stay clear when no new edge arrives
  p_eoi_clear_r7: assert property (@(posedge pclk) disable iff (!presetn)
    (eoi_stb && edge_ev == '0) |=> (edge_latch & $past(eoi_val)) == '0);

  // R8: an accepted debounced value only moves on a sample tick
  p_db_tick_r8: assert property (@(posedge pclk) disable iff (!presetn)
    !$stable(db_out) |-> $past(db_tick));
endmodule

bind gpio_apb_bank gpio_apb_bank_chk #(.NP(NP), .W(W)) u_chk (
  .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
  .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .db_tick(db_tick),
  .pad_in(pad_in), .pad_sync(pad_sync), .pad_oe(pad_oe), .irq(irq),
  .int_en(int_en), .int_mask(int_mask), .edge_latch(edge_latch),
  .edge_ev(edge_ev), .eoi_stb(eoi_stb), .eoi_val(eoi_val), .db_out(db_out)
);

// File: tb/sim_gpio_apb_bank.sv
module sim_gpio_apb_bank;
  localparam int NP = 4;
  localparam int W  = 32;
  localparam int T  = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic psel = 0, penable = 0, pwrite = 0, alt = 0, tick = 0;
  logic [7:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [127:0] pad = '0;
  wire  [31:0] prdata;
  wire  pready, irq;
  wire  [127:0] pad_out, pad_oe;

  gpio_apb_bank #(.NP(NP), .W(W), .DB_TICKS(T)) u0 (
    .pclk(clk), .presetn(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .alt_layout(alt), .db_tick(tick), .pad_in(pad), .pad_out(pad_out),
    .pad_oe(pad_oe), .irq(irq)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // behavioural reference state
  logic [31:0] m_dr[4], m_ddr[4];
  logic [31:0] m_en, m_mask, m_typ, m_pol, m_deb, m_dbo, m_prev, m_lat;
  logic [127:0] m_s1, m_s2;
  int m_cnt[32];

  function automatic logic [31:0] m_line();
    return (m_deb & m_dbo) | (~m_deb & m_s2[31:0]);
  endfunction

  function automatic logic [31:0] m_stat();
    logic [31:0] v = m_line(), r;
    for (int i = 0; i < 32; i++)
      r[i] = m_typ[i] ? (v[i] == m_pol[i]) : m_lat[i];
    return r & m_en & ~m_mask;
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h00, 8'h0C, 8'h18, 8'h24: return m_dr[int'(a) / 12];
      8'h04, 8'h10, 8'h1C, 8'h28: return m_ddr[(int'(a) - 4) / 12];
      8'h50: return m_line();
      8'h54: return m_s2[63:32];
      8'h58: return m_s2[95:64];
      8'h5C: return m_s2[127:96];
      8'h30: return m_en;
      8'h48: return m_deb;
      8'h34: return alt ? m_typ : m_mask;
      8'h38: return alt ? m_pol : m_typ;
      8'h3C: return alt ? m_stat() : m_pol;
      8'h40: return alt ? 32'h0 : m_stat();
      8'h44: return alt ? m_mask : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  task automatic m_write(input logic [7:0] a, input logic [31:0] d);
    case (a)
      8'h00, 8'h0C, 8'h18, 8'h24: m_dr[int'(a) / 12] = d;
      8'h04, 8'h10, 8'h1C, 8'h28: m_ddr[(int'(a) - 4) / 12] = d;
      8'h30: m_en = d;
      8'h48: m_deb = d;
      8'h34: if (alt) m_typ = d; else m_mask = d;
      8'h38: if (alt) m_pol = d; else m_typ = d;
      8'h3C: if (!alt) m_pol = d;
      8'h44: if (alt) m_mask = d;
      default: ;
    endcase
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < 4; p++) begin m_dr[p] = '0; m_ddr[p] = '0; end
      m_en = '0; m_mask = '0; m_typ = '0; m_pol = '0; m_deb = '0;
      m_dbo = '0; m_prev = '0; m_lat = '0; m_s1 = '0; m_s2 = '0;
      for (int i = 0; i < 32; i++) m_cnt[i] = 0;
    end else begin
      logic [31:0] v, clr;
      logic w, ev;
      v = m_line();
      w = psel && penable && pwrite;
      clr = (w && ((!alt && paddr == 8'h4C) || (alt && paddr == 8'h40))) ? pwdata : 32'h0;
      for (int i = 0; i < 32; i++) begin
        ev = m_en[i] && !m_typ[i] &&
             (m_pol[i] ? (v[i] && !m_prev[i]) : (!v[i] && m_prev[i]));
        m_lat[i] = m_en[i] && !m_typ[i] && ((m_lat[i] && !clr[i]) || ev);
      end
      m_prev = v;
      for (int i = 0; i < 32; i++) begin
        if (m_s2[i] == m_dbo[i]) m_cnt[i] = 0;
        else if (tick) begin
          if (m_cnt[i] == T - 1) begin m_dbo[i] = m_s2[i]; m_cnt[i] = 0; end
          else m_cnt[i]++;
        end
      end
      m_s2 = m_s1;
      m_s1 = pad;
      if (w) m_write(paddr, pwdata);
    end
  end

  task automatic chk(input logic [127:0] act, input logic [127:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // cycle-by-cycle comparison of outputs against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(pad_out, {m_dr[3], m_dr[2], m_dr[1], m_dr[0]}, "R1 pad_out");
      chk(pad_oe, {m_ddr[3], m_ddr[2], m_ddr[1], m_ddr[0]}, "R1 pad_oe");
      chk(128'(irq), 128'(|m_stat()), "R5 irq");
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1;
    #1 chk(128'(prdata), 128'(m_read(a)), tag);
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic rd_lit(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1;
    #1 chk(128'(prdata), 128'(m_read(a)), tag);
    chk(128'(prdata), 128'(exp), tag);
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pad_a(input logic [31:0] v);
    @(negedge clk); pad[31:0] = v;
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual still running expected finished");
    finish_run();
  end

  initial begin
    logic [31:0] lf;
    idle(3);
    rst_n = 1;
    idle(1);
    // R10 reset state
    chk(pad_oe, '0, "R10 oe");
    chk(128'(irq), 0, "R10 irq");
    foreach (m_dr[p]) begin
      rd_lit(8'(12 * p), 32'h0, "R10 data");
      rd_lit(8'(12 * p + 4), 32'h0, "R10 dir");
    end
    rd_lit(8'h30, 0, "R10 ien"); rd_lit(8'h40, 0, "R10 stat"); rd_lit(8'h48, 0, "R10 deb");

    // R1 data and direction
    for (int p = 0; p < 4; p++) begin
      wr(8'(12 * p), 32'hA5A50000 | p);
      wr(8'(12 * p + 4), 32'hFF00FF00 ^ p);
    end
    for (int p = 0; p < 4; p++) begin
      rd_lit(8'(12 * p), 32'hA5A50000 | p, "R1 data");
      rd_lit(8'(12 * p + 4), 32'hFF00FF00 ^ p, "R1 dir");
    end

    // R2 pin registers
    @(negedge clk); pad = {32'h11112222, 32'h33334444, 32'h55556666, 32'h0};
    idle(4);
    rd_lit(8'h50, 32'h0, "R2 pin0");
    rd_lit(8'h54, 32'h55556666, "R2 pin1");
    rd_lit(8'h58, 32'h33334444, "R2 pin2");
    rd_lit(8'h5C, 32'h11112222, "R2 pin3");

    // R3 undecoded offsets
    wr(8'h08, 32'hFFFFFFFF); wr(8'h2C, 32'hFFFFFFFF); wr(8'h60, 32'h1234); wr(8'h44, 32'hFFFF);
    rd_lit(8'h08, 0, "R3 rd08"); rd_lit(8'h2C, 0, "R3 rd2C");
    rd_lit(8'h60, 0, "R3 rd60"); rd_lit(8'h44, 0, "R3 rd44");
    rd_lit(8'h34, 0, "R3 mask untouched"); rd(8'h00, "R3 data0");

    // R6 level lines
    wr(8'h38, 32'h0F); wr(8'h3C, 32'h05); wr(8'h30, 32'h0F);
    idle(2);
    rd_lit(8'h40, 32'h0A, "R6 idle pins");
    set_pad_a(32'h1);
    idle(4);
    rd_lit(8'h40, 32'h0B, "R6 high line");
    // R5 mask
    wr(8'h34, 32'h0B);
    rd_lit(8'h40, 32'h0, "R5 masked");
    chk(128'(irq), 0, "R5 irq masked");
    wr(8'h34, 32'h0);
    chk(128'(irq), 1, "R5 irq unmasked");
    // R7 level lines ignore end-of-interrupt
    wr(8'h4C, 32'hFFFFFFFF);
    rd_lit(8'h40, 32'h0B, "R7 level after eoi");
    wr(8'h30, 32'h0);
    rd_lit(8'h40, 32'h0, "R5 disarmed");

    // R7 edge lines
    wr(8'h3C, 32'h305);
    set_pad_a(32'hC00);
    idle(4);
    wr(8'h30, 32'hF00);
    rd_lit(8'h40, 32'h0, "R7 no spurious edge");
    set_pad_a(32'h900);
    idle(4);
    rd_lit(8'h40, 32'h500, "R7 rise and fall");
    set_pad_a(32'h800);
    idle(4);
    rd_lit(8'h40, 32'h500, "R7 held latch");
    wr(8'h4C, 32'h100);
    rd_lit(8'h40, 32'h400, "R7 single clear");
    wr(8'h4C, 32'hFFFFFFFF);
    rd_lit(8'h40, 32'h0, "R7 clear all");

    // R4 alternate layout
    @(negedge clk); alt = 1;
    rd_lit(8'h34, 32'h0F, "R4 alt type");
    rd_lit(8'h38, 32'h305, "R4 alt pol");
    rd_lit(8'h44, 32'h0, "R4 alt mask");
    rd_lit(8'h4C, 32'h0, "R4 alt hole");
    set_pad_a(32'h0);
    idle(4);
    rd_lit(8'h3C, 32'h800, "R4 alt status");
    wr(8'h40, 32'h800);
    rd_lit(8'h3C, 32'h0, "R4 alt eoi");
    wr(8'h44, 32'h1);
    rd_lit(8'h44, 32'h1, "R4 alt mask write");
    @(negedge clk); alt = 0;
    rd_lit(8'h34, 32'h1, "R4 mask seen in default map");
    wr(8'h34, 32'h0); wr(8'h30, 32'h0);

    // R8 debounce
    wr(8'h48, 32'h10000);
    rd_lit(8'h48, 32'h10000, "R8 deb reg");
    @(negedge clk); tick = 1;
    set_pad_a(32'h10000);
    idle(1);
    set_pad_a(32'h0);
    idle(8);
    rd_lit(8'h50, 32'h0, "R8 short glitch");
    set_pad_a(32'h10000);
    idle(10);
    rd_lit(8'h50, 32'h10000, "R8 held level");
    @(negedge clk); tick = 0;
    set_pad_a(32'h0);
    idle(10);
    rd_lit(8'h50, 32'h10000, "R8 no ticks");
    @(negedge clk); tick = 1;
    idle(10);
    rd_lit(8'h50, 32'h0, "R8 ticks resume");

    // R9 other ports raise nothing
    wr(8'h38, 32'h0); wr(8'h3C, 32'hFFFFFFFF); wr(8'h30, 32'hFFFFFFFF);
    rd_lit(8'h40, 32'h0, "R9 quiet start");
    @(negedge clk); pad[127:32] = ~pad[127:32];
    idle(6);
    chk(128'(irq), 0, "R9 irq");
    rd_lit(8'h40, 32'h0, "R9 status");
    rd_lit(8'h54, 32'hAAAA9999, "R2 pin1 inverted");

    // mixed phase checked against the model
    wr(8'h38, 32'h0000FFFF); wr(8'h3C, 32'hAAAA5555); wr(8'h48, 32'h00FF0000);
    lf = 32'h1;
    for (int it = 0; it < 400; it++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      @(negedge clk);
      tick = lf[5];
      if (lf[2:0] == 3'd0) pad[31:0] = pad[31:0] ^ (lf & 32'h00F300F3);
      if (it % 16 == 7) begin
        rd(8'h40, "R7 mixed status");
        rd(8'h50, "R8 mixed pin");
        wr(8'h4C, lf ^ 32'h0F0F0F0F);
      end
    end
    idle(4);
    rd(8'h40, "R5 final status");
    finish_run();
  end
endmodule